// File: doc/BRIEF.md
# SIMT Branch Divergence Stack

This block tracks which threads of a warp are live while the warp runs through data-dependent branches. A front end decodes a split or a join command and presents it with a per-thread predicate vector, the warp's active-thread mask and a resume PC. The block keeps a stack of reconvergence entries. It produces the next active-thread mask and, when a join has to jump, a PC redirect.

A split first checks whether the active threads agree on the predicate. Threads whose mask bit is clear do not take part in this check. If they agree, one uniform marker entry is pushed and the mask stays as it is. If they disagree, two entries are pushed: a fall-through entry holding the whole mask, then an entry holding the predicate-true threads and the resume PC. The live mask narrows to the predicate-false threads. A join pops the top entry and restores the mask from it. When that entry is neither uniform nor fall-through, the join also redirects the PC. Error pulses report a split with no active thread, a push that does not fit, and a join on an empty stack.

Top module: `simt_div_stack`

## Requirements
- R1: A synchronous active-high reset empties the stack, sets `mask_o` to thread 0 only (value 0001 for four threads) and clears all pulse outputs.
- R2: A command acts only when `cmd_valid` is 1 and `cmd_func` is 2 (split) or 3 (join). Any other function value, or `cmd_valid` low, leaves the mask, the stack and every output unchanged.
- R3: On a split where the predicate-true subset of the active threads is empty or equal to the whole active set, one uniform entry holding the active mask is pushed, and `mask_o` takes the active mask. Predicate bits of inactive threads are ignored.
- R4: On a split where the active threads disagree, a fall-through entry with the full active mask is pushed, then a resume entry with the predicate-true active threads and `resume_pc`. `mask_o` becomes the active threads whose predicate is false.
- R5: A join whose top entry is uniform sets `mask_o` to the stored mask, pops the entry and raises no redirect.
- R6: A join whose top entry is a resume entry pulses `redirect_o` with `redirect_pc_o` equal to the stored PC, sets `mask_o` to the stored mask and pops the entry.
- R7: A join whose top entry is fall-through sets `mask_o` to the stored mask, pops the entry and raises no redirect.
- R8: A split whose active mask is all zero pulses `diverge_o` and pushes nothing. `mask_o` is unchanged.
- R9: A split that needs more free slots than remain pulses `overflow_o`, and the stack and `mask_o` stay unchanged. A uniform split needs one slot and a divergent split needs two.
- R10: A join on an empty stack pulses `underflow_o`, and `mask_o` is unchanged.
- R11: All outputs are registered and change at the first clock edge after the command. `redirect_o`, `diverge_o`, `overflow_o` and `underflow_o` last one cycle, and at most one of the last three is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_func | input | 3 | Function code: 2 split, 3 join |
| thr_mask_i | input | THREADS | Active-thread mask of the warp |
| pred_i | input | THREADS | Per-thread predicate (nonzero source register) |
| resume_pc | input | 32 | PC stored in the resume entry on a divergent split |
| mask_o | output | THREADS | Next active-thread mask |
| redirect_o | output | 1 | One-cycle PC redirect pulse |
| redirect_pc_o | output | 32 | Redirect target, valid with `redirect_o` |
| diverge_o | output | 1 | Split seen with no active thread |
| overflow_o | output | 1 | Split rejected for lack of stack room |
| underflow_o | output | 1 | Join rejected on an empty stack |

## Verification
The assertions assume that `cmd_func`, `thr_mask_i` and `pred_i` are driven to known values in every cycle after reset, and that at most one command is presented per cycle. The unrelated pass-through of `thr_mask_i` on a uniform split is taken as the warp's real mask. The stimulus changes inputs only on the falling clock edge. It presents exactly one command per cycle and drives the mask input with the values a warp would hold, including the all-zero mask and masks that leave some predicate bits irrelevant. This keeps every input defined at each rising edge.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  localparam logic [2:0] FN_SPLIT = 3'd2;
  localparam logic [2:0] FN_JOIN  = 3'd3;
  localparam int         PC_W     = 32;
  localparam int         MAX_THR  = 64;

  // all active threads agree when the true subset is empty or the whole set
  function automatic logic preds_agree(input logic [MAX_THR-1:0] act,
                                       input logic [MAX_THR-1:0] prd);
    logic [MAX_THR-1:0] hit;
    hit = act & prd;
    return (hit == '0) || (hit == act);
  endfunction
endpackage

// File: rtl/div_split_eval.sv
module div_split_eval
  import simt_div_pkg::*;
#(
  parameter int THREADS = 4
) (
  input  logic [THREADS-1:0] act_i,
  input  logic [THREADS-1:0] pred_i,
  output logic [THREADS-1:0] taken_o,
  output logic [THREADS-1:0] fallen_o,
  output logic               agree_o,
  output logic               none_active_o
);
  localparam int PAD = MAX_THR - THREADS;

  always_comb begin
    taken_o       = act_i & pred_i;
    fallen_o      = act_i & ~pred_i;
    agree_o       = preds_agree({{PAD{1'b0}}, act_i}, {{PAD{1'b0}}, pred_i});
    none_active_o = (act_i == '0);
  end
endmodule

// File: rtl/div_entry_stack.sv
module div_entry_stack
  import simt_div_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push_one,
  input  logic                     push_two,
  input  logic                     pop,
  input  logic [THREADS-1:0]       w0_mask,
  input  logic                     w0_uni,
  input  logic                     w0_ft,
  input  logic [THREADS-1:0]       w1_mask,
  input  logic [PC_W-1:0]          w1_pc,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic [THREADS-1:0]       top_mask,
  output logic [PC_W-1:0]          top_pc,
  output logic                     top_uni,
  output logic                     top_ft,
  output logic                     empty_o,
  output logic                     room1_o,
  output logic                     room2_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]   count;
  logic [THREADS-1:0] e_mask [DEPTH];
  logic [PC_W-1:0]    e_pc   [DEPTH];
  logic               e_uni  [DEPTH];
  logic               e_ft   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        e_mask[i] <= '0;
        e_pc[i]   <= '0;
        e_uni[i]  <= 1'b0;
        e_ft[i]   <= 1'b0;
      end else if ((push_one || push_two) && (32'(count) == i)) begin
        e_mask[i] <= w0_mask;
        e_pc[i]   <= '0;
        e_uni[i]  <= w0_uni;
        e_ft[i]   <= w0_ft;
      end else if (push_two && (32'(count) + 1 == i)) begin
        e_mask[i] <= w1_mask;
        e_pc[i]   <= w1_pc;
        e_uni[i]  <= 1'b0;
        e_ft[i]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (push_two) count <= count + CNT_W'(2);
    else if (push_one) count <= count + CNT_W'(1);
    else if (pop)      count <= count - CNT_W'(1);
  end

  always_comb begin
    top_mask = '0;
    top_pc   = '0;
    top_uni  = 1'b0;
    top_ft   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (32'(count) == i + 1) begin
        top_mask = e_mask[i];
        top_pc   = e_pc[i];
        top_uni  = e_uni[i];
        top_ft   = e_ft[i];
      end
    end
  end

  assign count_o = count;
  assign empty_o = (count == '0);
  assign room1_o = (32'(count) + 1 <= DEPTH);
  assign room2_o = (32'(count) + 2 <= DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH); // R9
  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (rst)
    pop |=> count == $past(count) - CNT_W'(1)); // R5
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack
  import simt_div_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_func,
  input  logic [THREADS-1:0] thr_mask_i,
  input  logic [THREADS-1:0] pred_i,
  input  logic [31:0]        resume_pc,
  output logic [THREADS-1:0] mask_o,
  output logic               redirect_o,
  output logic [31:0]        redirect_pc_o,
  output logic               diverge_o,
  output logic               overflow_o,
  output logic               underflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [THREADS-1:0] taken, fallen, top_mask;
  logic               agree, none_active;
  logic [CNT_W-1:0]   stk_count;
  logic [PC_W-1:0]    top_pc;
  logic               top_uni, top_ft, empty, room1, room2;

  // named internal events
  logic split_cmd, join_cmd, diverge_evt, split_uni, split_div;
  logic ovf_evt, unf_evt, push_one, push_two, pop, jump_evt;

  div_split_eval #(.THREADS(THREADS)) u_eval (
    .act_i(thr_mask_i), .pred_i(pred_i), .taken_o(taken),
    .fallen_o(fallen), .agree_o(agree), .none_active_o(none_active)
  );

  always_comb begin
    split_cmd   = cmd_valid && (cmd_func == FN_SPLIT);
    join_cmd    = cmd_valid && (cmd_func == FN_JOIN);
    diverge_evt = split_cmd && none_active;
    split_uni   = split_cmd && !none_active && agree;
    split_div   = split_cmd && !none_active && !agree;
    ovf_evt     = (split_uni && !room1) || (split_div && !room2);
    push_one    = split_uni && room1;
    push_two    = split_div && room2;
    unf_evt     = join_cmd && empty;
    pop         = join_cmd && !empty;
    jump_evt    = pop && !top_uni && !top_ft;
  end

  div_entry_stack #(.DEPTH(DEPTH), .THREADS(THREADS)) u_stack (
    .clk(clk), .rst(rst),
    .push_one(push_one), .push_two(push_two), .pop(pop),
    .w0_mask(thr_mask_i), .w0_uni(push_one), .w0_ft(push_two),
    .w1_mask(taken), .w1_pc(resume_pc),
    .count_o(stk_count), .top_mask(top_mask), .top_pc(top_pc),
    .top_uni(top_uni), .top_ft(top_ft), .empty_o(empty),
    .room1_o(room1), .room2_o(room2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o        <= THREADS'(1);
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      diverge_o     <= 1'b0;
      overflow_o    <= 1'b0;
      underflow_o   <= 1'b0;
    end else begin
      if (push_one)      mask_o <= thr_mask_i;
      else if (push_two) mask_o <= fallen;
      else if (pop)      mask_o <= top_mask;
      redirect_o  <= jump_evt;
      if (jump_evt) redirect_pc_o <= top_pc;
      diverge_o   <= diverge_evt;
      overflow_o  <= ovf_evt;
      underflow_o <= unf_evt;
    end
  end

  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> $stable(stk_count) && (mask_o == $past(mask_o))); // R9
  AST_UNF_MASK: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> mask_o == $past(mask_o)); // R10
  AST_DIV_NOPUSH: assert property (@(posedge clk) disable iff (rst)
    diverge_evt |=> $stable(stk_count) && diverge_o); // R8
  AST_UNI_MASK: assert property (@(posedge clk) disable iff (rst)
    push_one |=> mask_o == $past(thr_mask_i)); // R3
  AST_SPLIT_GROW: assert property (@(posedge clk) disable iff (rst)
    push_two |=> stk_count == $past(stk_count) + CNT_W'(2)); // R4
  AST_REDIR_AFTER_JOIN: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(join_cmd)); // R6
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0({diverge_o, overflow_o, underflow_o})); // R11
endmodule

// File: tb/simt_div_stack_tb.sv
module simt_div_stack_tb;
  typedef struct packed {
    logic        valid;
    logic [2:0]  func;
    logic [3:0]  mask;
    logic [3:0]  pred;
    logic [31:0] pc;
    logic [3:0]  e_mask;
    logic        e_redir;
    logic [31:0] e_tgt;
    logic        e_err;
    logic        e_ovf;
    logic        e_unf;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1,3'd3,4'b1111,4'b0000,32'h0,  4'b0001,1'b0,32'h0,  1'b0,1'b0,1'b1},
    '{1'b1,3'd2,4'b1111,4'b1111,32'h100,4'b1111,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0011,32'h200,4'b1100,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1100,4'b0111,32'h300,4'b1000,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd5,4'b1111,4'b1111,32'h0,  4'b1000,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b0,3'd2,4'b1111,4'b0011,32'h0,  4'b1000,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b1000,4'b0000,32'h0,  4'b0100,1'b1,32'h300,1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b0100,4'b0000,32'h0,  4'b1100,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b1100,4'b0000,32'h0,  4'b0011,1'b1,32'h200,1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b0011,4'b0000,32'h0,  4'b1111,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b0101,4'b1010,32'h0,  4'b0101,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b1111,4'b0000,32'h0,  4'b0101,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b1111,4'b0000,32'h0,  4'b1111,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd3,4'b1111,4'b0000,32'h0,  4'b1111,1'b0,32'h0,  1'b0,1'b0,1'b1},
    '{1'b1,3'd2,4'b0000,4'b1111,32'h0,  4'b1111,1'b0,32'h0,  1'b1,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0001,32'h410,4'b1110,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0001,32'h420,4'b1110,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0001,32'h430,4'b1110,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0001,32'h440,4'b1110,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b1111,4'b0001,32'h450,4'b1110,1'b0,32'h0,  1'b0,1'b1,1'b0},
    '{1'b1,3'd3,4'b1110,4'b0000,32'h0,  4'b0001,1'b1,32'h440,1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b0011,4'b0001,32'h460,4'b0001,1'b0,32'h0,  1'b0,1'b1,1'b0},
    '{1'b1,3'd2,4'b0111,4'b0111,32'h0,  4'b0111,1'b0,32'h0,  1'b0,1'b0,1'b0},
    '{1'b1,3'd2,4'b0011,4'b0000,32'h0,  4'b0111,1'b0,32'h0,  1'b0,1'b1,1'b0},
    '{1'b1,3'd3,4'b1111,4'b0000,32'h0,  4'b0111,1'b0,32'h0,  1'b0,1'b0,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_func = 3'd0;
  logic [3:0]  thr_mask_i = 4'b0;
  logic [3:0]  pred_i = 4'b0;
  logic [31:0] resume_pc = 32'h0;
  logic [3:0]  mask_o;
  logic        redirect_o, diverge_o, overflow_o, underflow_o;
  logic [31:0] redirect_pc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  simt_div_stack u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .thr_mask_i(thr_mask_i), .pred_i(pred_i), .resume_pc(resume_pc),
    .mask_o(mask_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .diverge_o(diverge_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  function automatic string tag_of(vec_t v);
    if (v.e_unf)                        return "R10";
    if (v.e_ovf)                        return "R9";
    if (v.e_err)                        return "R8";
    if (v.e_redir)                      return "R6";
    if (!v.valid || !(v.func inside {3'd2, 3'd3})) return "R2";
    if (v.func == 3'd3)                 return "R5/R7";
    if (((v.mask & v.pred) == 4'b0) || ((v.mask & v.pred) == v.mask)) return "R3";
    return "R4";
  endfunction

  task automatic check_out(string req, logic [3:0] em, logic er, logic [31:0] et,
                           logic ee, logic eo, logic eu);
    logic ok;
    n_chk++;
    ok = (mask_o == em) && (redirect_o == er) && (diverge_o == ee) &&
         (overflow_o == eo) && (underflow_o == eu) && (!er || redirect_pc_o == et);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got mask=%b redir=%b pc=%h err=%b ovf=%b unf=%b exp mask=%b redir=%b pc=%h err=%b ovf=%b unf=%b",
               req, mask_o, redirect_o, redirect_pc_o, diverge_o, overflow_o, underflow_o,
               em, er, et, ee, eo, eu);
    end
  endtask

  task automatic drive(logic v, logic [2:0] f, logic [3:0] m, logic [3:0] p, logic [31:0] pc);
    cmd_valid  = v;
    cmd_func   = f;
    thr_mask_i = m;
    pred_i     = p;
    resume_pc  = pc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_out("R1", 4'b0001, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].valid, VEC[i].func, VEC[i].mask, VEC[i].pred, VEC[i].pc);
      @(posedge clk);
      #5;
      check_out(tag_of(VEC[i]), VEC[i].e_mask, VEC[i].e_redir, VEC[i].e_tgt,
                VEC[i].e_err, VEC[i].e_ovf, VEC[i].e_unf);
    end

    // R11: output holds before the edge, updates right after it
    @(negedge clk);
    drive(1'b1, 3'd2, 4'b1111, 4'b1111, 32'h0);
    #1;
    check_out("R11", 4'b0111, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #5;
    check_out("R11", 4'b1111, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    // R11: idle cycle, pulses drop
    @(negedge clk);
    drive(1'b0, 3'd0, 4'b1111, 4'b0000, 32'h0);
    @(posedge clk);
    #5;
    check_out("R11", 4'b1111, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R1: reset in mid run empties the stack
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_out("R1", 4'b0001, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 3'd3, 4'b1111, 4'b0000, 32'h0);
    @(posedge clk);
    #5;
    check_out("R1", 4'b0001, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1);

    @(negedge clk);
    drive(1'b0, 3'd0, 4'b0000, 4'b0000, 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no end, exp end of run");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule